// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the 16-bit product of two 8-bit unsigned operands over a series of clock cycles. A single ripple adder is used for every partial product. A Moore controller walks the multiplier from its least significant bit upward. For each bit that is 1, it spends one cycle adding the registered multiplicand into the upper half of the partial product. For every bit, 0 or 1, it spends one cycle shifting the partial product right by one position.

The carry out of the adder is held in a dedicated one-bit flop. On the following shift it enters the top of the product, and it is cleared in the same cycle. This keeps sums that overflow eight bits from being lost.

A caller holds start high to run a multiplication and reads the product when done pulses. The product then stays frozen until start is dropped and raised again. Dropping start at any point abandons the run and returns the controller to idle.

Top module: `shift_add_mul`

## Requirements
- R1: For any unsigned operand pair, the product output equals multiplicand × multiplier when done pulses. This covers operands of 0, 1 and 255.
- R2: A carry out of an add cycle is preserved. It enters product bit 15 on the next shift and is cleared to 0 by that shift. As a result, 255 × 255 yields 65025 (0xFE01).
- R3: Number the rising edges from 1, where edge 1 is the first edge at which start is sampled high while idle. Done becomes visible after edge 11 + k, where k is the number of 1 bits in the multiplier.
- R4: Done is high for exactly one clock cycle per run, even while start stays high.
- R5: After done, the product output does not change for as long as start stays high, nor after start is dropped, until a new run begins.
- R6: Sampling start low returns the controller to idle from any state. The next run clears the product and the saved carry before adding, so a partial earlier run has no effect on the result.
- R7: The operands are captured at edge 2 of a run. Changing the operand inputs after that edge has no effect on the product.
- R8: After reset, the product output is 0 and done is 0.
- R9: In any cycle, at most one of the clear, add and shift operations is applied to the partial product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Held high to run a multiplication; low forces idle |
| multiplicandIn | input | 8 | Unsigned multiplicand |
| multiplierIn | input | 8 | Unsigned multiplier |
| productOut | output | 16 | Unsigned product |
| doneOut | output | 1 | One-cycle pulse when the product is valid |

## Verification
Two things share a single cycle in this block. In every shift cycle, the saved carry is consumed into bit 15 and cleared at once. In the abort case, start falls while an add or shift is under way. The first is provoked by multipliers with runs of adjacent 1 bits and large multiplicands, 255 × 255 above all, and by runs of 0 bits after a carrying add. Each is judged by comparing the product against a reference multiplication. The second is provoked by dropping start a few cycles into a run and then starting a fresh pair. That pair must produce an exact product with the predicted latency, which shows that the leftover partial sum and carry were cleared.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

  // Strobes from the controller to the datapath, one per operation.
  typedef struct packed {
    logic loadOps;  // capture multiplicand and multiplier
    logic clear;    // zero partial product and saved carry
    logic add;      // write adder sum to upper half, keep carry
    logic shift;    // shift right, saved carry into the top bit
  } samCtl_t;

endpackage

// File: rtl/sam_adder.sv
module sam_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  logic [WIDTH:0] chain;

  assign chain[0] = carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sumOut[i]   = aIn[i] ^ bIn[i] ^ chain[i];
    assign chain[i+1]  = (aIn[i] & bIn[i]) | ((aIn[i] ^ bIn[i]) & chain[i]);
  end

  assign carryOut = chain[WIDTH];

endmodule

// File: rtl/sam_datapath.sv
module sam_datapath
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  samCtl_t            ctl,
  input  logic [WIDTH-1:0]   multiplicandIn,
  input  logic [WIDTH-1:0]   multiplierIn,
  output logic [WIDTH-1:0]   multBits,
  output logic [2*WIDTH-1:0] productOut
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcandReg;
  logic [WIDTH-1:0] mplierReg;
  logic [PW-1:0]    prodReg;
  logic             savedCarry;
  logic [WIDTH-1:0] sumBits;
  logic             sumCarry;

  sam_adder #(.WIDTH(WIDTH)) u_adder (
    .aIn      (prodReg[PW-1:WIDTH]),
    .bIn      (mcandReg),
    .carryIn  (1'b0),
    .sumOut   (sumBits),
    .carryOut (sumCarry)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandReg  <= '0;
      mplierReg <= '0;
    end else if (ctl.loadOps) begin
      mcandReg  <= multiplicandIn;
      mplierReg <= multiplierIn;
    end
  end

  // Priority: clear, then add, then shift.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodReg    <= '0;
      savedCarry <= 1'b0;
    end else if (ctl.clear) begin
      prodReg    <= '0;
      savedCarry <= 1'b0;
    end else if (ctl.add) begin
      prodReg[PW-1:WIDTH] <= sumBits;
      savedCarry          <= sumCarry;
    end else if (ctl.shift) begin
      prodReg    <= {savedCarry, prodReg[PW-1:1]};
      savedCarry <= 1'b0;
    end
  end

  assign multBits   = mplierReg;
  assign productOut = prodReg;

  // R2: a shift leaves no carry behind.
  p_carry_consumed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shift && !ctl.add && !ctl.clear) |=> !savedCarry);

  // R2: the carry held before a shift lands in the top product bit.
  p_carry_enters_top_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shift && !ctl.add && !ctl.clear) |=> (prodReg[PW-1] == $past(savedCarry)));

  // R6: clear wipes the partial product and the carry.
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (prodReg == '0 && !savedCarry));

endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [WIDTH-1:0] multBits,
  output samCtl_t          ctl,
  output logic             doneOut
);

  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_CHECK, S_ADD, S_SHIFT, S_FINISH, S_HOLD
  } samState_t;

  samState_t       state, nextState;
  logic [IDXW-1:0] bitIdx;
  logic [IDXW-1:0] nextIdx;
  logic            lastBit;

  assign nextIdx = IDXW'(bitIdx + 1'b1);
  assign lastBit = (bitIdx == IDXW'(WIDTH - 1));

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:   nextState = S_SETUP;
      S_SETUP:  nextState = S_CHECK;
      S_CHECK:  nextState = multBits[bitIdx] ? S_ADD : S_SHIFT;
      S_ADD:    nextState = S_SHIFT;
      S_SHIFT:  nextState = lastBit ? S_FINISH
                          : (multBits[nextIdx] ? S_ADD : S_SHIFT);
      S_FINISH: nextState = S_HOLD;
      S_HOLD:   nextState = S_HOLD;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitIdx <= '0;
    end else if (!startIn) begin
      state  <= S_IDLE;
      bitIdx <= '0;
    end else begin
      state <= nextState;
      if (state == S_SETUP)
        bitIdx <= '0;
      else if (state == S_SHIFT && !lastBit)
        bitIdx <= nextIdx;
    end
  end

  // Moore decode: strobes depend on the state alone.
  always_comb begin
    ctl         = '0;
    ctl.loadOps = (state == S_SETUP);
    ctl.clear   = (state == S_SETUP);
    ctl.add     = (state == S_ADD);
    ctl.shift   = (state == S_SHIFT);
  end

  assign doneOut = (state == S_FINISH);

  // R4: done never lasts two cycles.
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R6: start low sends the controller home.
  p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |=> (state == S_IDLE));

  // R9: only one product operation per cycle.
  p_one_op_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.clear, ctl.add, ctl.shift}));

  // R3: every add is followed directly by a shift while start holds.
  p_add_then_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.add && startIn) |=> ctl.shift);

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [WIDTH-1:0]   multiplicandIn,
  input  logic [WIDTH-1:0]   multiplierIn,
  output logic [2*WIDTH-1:0] productOut,
  output logic               doneOut
);

  samCtl_t          ctl;
  logic [WIDTH-1:0] multBits;

  sam_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .multBits (multBits),
    .ctl      (ctl),
    .doneOut  (doneOut)
  );

  sam_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .multiplicandIn (multiplicandIn),
    .multiplierIn   (multiplierIn),
    .multBits       (multBits),
    .productOut     (productOut)
  );

  // R5: once start has been low for a cycle, the product is frozen.
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |-> ##2 $stable(productOut));

  // R5: the cycle after done, the product is unchanged.
  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> $stable(productOut));

endmodule

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;

  localparam int W = 8;

  typedef struct {
    logic [2*W-1:0] prod;
    int             lat;
    int             startEdge;
    logic [W-1:0]   a;
    logic [W-1:0]   b;
  } expItem_t;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           startIn = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] productOut;
  logic           doneOut;

  int checks = 0;
  int fails = 0;
  int edgeCnt = 0;
  expItem_t expQ[$];

  shift_add_mul #(.WIDTH(W)) u_dut (
    .clk            (clk),
    .rstN           (rstN),
    .startIn        (startIn),
    .multiplicandIn (mcand),
    .multiplierIn   (mplier),
    .productOut     (productOut),
    .doneOut        (doneOut)
  );

  always #5ns clk = ~clk;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: pops an expected item on each done pulse and compares.
  always @(negedge clk) begin
    if (rstN && doneOut) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4", "done without pending run", 1, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (it.a == 8'hFF && it.b == 8'hFF)
          check(productOut == it.prod, "R2", "255x255 product", productOut, it.prod);
        else
          check(productOut == it.prod, "R1", "product", productOut, it.prod);
        check((edgeCnt - it.startEdge) == it.lat, "R3", "latency",
              edgeCnt - it.startEdge, it.lat);
      end
    end
  end

  // Driver: one run, optional operand change mid-run (R7).
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit perturb);
    expItem_t it;
    logic [2*W-1:0] held;
    @(negedge clk);
    mcand  = a;
    mplier = b;
    it.a = a;
    it.b = b;
    it.prod = (2*W)'(a) * (2*W)'(b);
    it.lat = 11 + $countones(b);
    it.startEdge = edgeCnt;
    expQ.push_back(it);
    startIn = 1'b1;
    if (perturb) begin
      repeat (4) @(negedge clk);
      mcand  = ~a;
      mplier = ~b;
    end
    do @(negedge clk); while (!doneOut);
    held = productOut;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(doneOut == 1'b0, "R4", "done held high", doneOut, 0);
      check(productOut == held, "R5", "product moved with start high", productOut, held);
    end
    startIn = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(productOut == held, "R5", "product moved after start low", productOut, held);
    end
    if (perturb)
      check(held == it.prod, "R7", "late operand change", held, it.prod);
  endtask

  // Abort: start dropped partway through a run (R6).
  task automatic abortOp(input logic [W-1:0] a, input logic [W-1:0] b,
                         input int cyc);
    @(negedge clk);
    mcand  = a;
    mplier = b;
    startIn = 1'b1;
    repeat (cyc) @(negedge clk);
    startIn = 1'b0;
    repeat (2) @(negedge clk);
    check(doneOut == 1'b0, "R6", "done after abort", doneOut, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [W-1:0] corner [3];
    int seedDummy;
    corner[0] = 8'd0;
    corner[1] = 8'd1;
    corner[2] = 8'd255;
    seedDummy = $urandom(32'd1234);

    repeat (3) @(negedge clk);
    check(productOut == '0, "R8", "reset product", productOut, 0);
    check(doneOut == 1'b0, "R8", "reset done", doneOut, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 first: the carry-sensitive case.
    runOp(8'd255, 8'd255, 1'b0);

    // R1 corners.
    foreach (corner[i])
      foreach (corner[j])
        runOp(corner[i], corner[j], 1'b0);

    // R2: alternating and clustered bits with large multiplicands.
    runOp(8'd255, 8'b1010_1010, 1'b0);
    runOp(8'd200, 8'b1111_0000, 1'b0);
    runOp(8'd129, 8'b0000_0011, 1'b0);

    // R6: aborts at various depths, each followed by a fresh run.
    abortOp(8'd255, 8'd255, 3);
    runOp(8'd17, 8'd3, 1'b0);
    abortOp(8'd250, 8'd127, 9);
    runOp(8'd1, 8'd128, 1'b0);
    abortOp(8'd99, 8'd255, 14);
    runOp(8'd0, 8'd0, 1'b0);

    // R7: operands changed after capture.
    runOp(8'd77, 8'd201, 1'b1);
    runOp(8'd255, 8'd255, 1'b1);

    // R1: random pairs.
    for (int n = 0; n < 300; n++)
      runOp(W'($urandom), W'($urandom), 1'b0);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R1", "runs left without done", expQ.size(), 0);
    report();
  end

endmodule